// File: doc/BRIEF.md
# SIMT Warp Issue Scheduler

This block picks, once every two core clocks, one resident warp to send its next instruction to a 16-lane SIMD datapath. Each warp slot reports whether it is resident, a priority value, and the register indices of its next instruction: two sources and a destination, plus a latency value. The scheduler keeps a per-warp bitmap of destination registers with writes still in flight. A warp may be chosen only when none of its three registers is marked. An issue marks the destination register. A writeback input clears the mark for one warp and one register.

A chosen warp of 32 threads enters the datapath as two groups of 16 threads over four core cycles, two cycles per group. A later issue waits until the previous warp has reached its last beat, so beats flow back to back. If a free issue slot finds no eligible warp, the block reports a no-issue cycle and sends no beats. Among eligible warps the highest priority value wins. Ties go to the lowest warp index at or after a rotating pointer. That pointer then moves to the slot just past the warp that issued.

The environment treats an `issue_valid` cycle for warp w as acceptance of that warp's instruction, and presents the warp's following instruction from the next cycle on.

Top module: `warp_issue_sched`

## Requirements
- R1: While `rst` is high at a clock edge, and in the cycle after that edge, `issue_valid`, `no_issue` and `beat_valid` are 0, every scoreboard mark is cleared and the rotating pointer is 0. The first edge with `rst` low is an issue slot.
- R2: Issue slots fall on every second edge after reset. `issue_valid` and `no_issue` are each high for at most one cycle, and never in two consecutive cycles.
- R3: A warp is eligible only when `warp_valid` is set for it and the scoreboard marks none of its source A, source B or destination registers.
- R4: Among eligible warps in a free slot, the warp with the numerically largest `warp_prio` value is issued.
- R5: Among eligible warps of equal priority, the first warp counting upward from the rotating pointer, with wrap from NW-1 to 0, is issued. After an issue the pointer becomes the issued index plus one, modulo NW.
- R6: An issue marks the issued warp's destination register from the next cycle on. A `wb_en` pulse clears the mark for (`wb_warp`, `wb_reg`) from the next cycle on. The writeback does not affect eligibility in the slot at the same edge.
- R7: The edge that raises `issue_valid` also starts four beat cycles. All four carry `beat_warp` equal to the issued warp. The first two have `beat_half`=0 and `beat_base`=0. The last two have `beat_half`=1 and `beat_base`=16.
- R8: No issue is made in a slot whose edge comes before the previous warp's last beat cycle. Such a slot raises neither `issue_valid` nor `no_issue`, so two issues are at least four cycles apart.
- R9: A free slot with no eligible warp raises `no_issue` for one cycle, with `beat_valid` low. The pointer and scoreboard stay unchanged.
- R10: With `issue_valid`, the outputs `issue_dst` and `issue_lat` equal the issued warp's destination index and latency value as presented at the issuing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| warp_valid | input | NW | Resident flag per warp |
| warp_prio | input | NW*PW | Priority per warp, warp w at bits [w*PW +: PW] |
| warp_src_a | input | NW*RW | First source register index per warp |
| warp_src_b | input | NW*RW | Second source register index per warp |
| warp_dst | input | NW*RW | Destination register index per warp |
| warp_lat | input | NW*LW | Latency value per warp |
| wb_en | input | 1 | Writeback strobe |
| wb_warp | input | WIW | Warp of the writeback |
| wb_reg | input | RW | Register of the writeback |
| issue_valid | output | 1 | A warp issued at the last edge |
| issue_warp | output | WIW | Issued warp index |
| issue_dst | output | RW | Issued destination register |
| issue_lat | output | LW | Issued latency value |
| no_issue | output | 1 | Free slot with no eligible warp |
| beat_valid | output | 1 | A half-warp beat is in the datapath |
| beat_half | output | 1 | Which 16-thread group the beat belongs to |
| beat_base | output | TBW | First thread index of the beat's group |
| beat_warp | output | WIW | Warp owning the beat |

## Verification
The bench begins with an empty machine, where only no-issue slots should appear. It then runs one lone warp to pin the beat sequence and the carried destination and latency. A read-after-write hazard follows: it holds a warp back until a writeback frees it. Next, sets of equal-priority and mixed-priority warps around the pointer, including a wrap from the top index to 0, tell priority order apart from rotation order. Two always-ready warps with distinct destinations show the four-cycle spacing and the silent busy slot. A long random run with small register ranges then produces dense hazards and writebacks, and every output is compared with a behavioural model on every clock.

// File: rtl/wis_pkg.sv
package wis_pkg;

  // Cycles each half-warp group spends entering the datapath.
  localparam int CYCLES_PER_GROUP = 2;

  // Forward distance from ptr to idx on a ring of n slots.
  function automatic int ring_dist(input int idx, input int ptr, input int n);
    if (idx >= ptr) return idx - ptr;
    return idx + n - ptr;
  endfunction

endpackage

// File: rtl/wis_scoreboard.sv
module wis_scoreboard #(
  parameter int NW = 24,
  parameter int NR = 16,
  localparam int WIW = $clog2(NW),
  localparam int RW = $clog2(NR)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [WIW-1:0]   set_warp,
  input  logic [RW-1:0]    set_reg,
  input  logic             clr_en,
  input  logic [WIW-1:0]   clr_warp,
  input  logic [RW-1:0]    clr_reg,
  output logic [NW*NR-1:0] pend
);
  localparam int IXW = $clog2(NW * NR);

  logic [NW*NR-1:0] pend_q;
  logic [IXW-1:0]   set_idx, clr_idx;
  logic             clr_ok;

  always_comb begin
    set_idx = IXW'(int'(set_warp) * NR + int'(set_reg));
    clr_idx = IXW'(int'(clr_warp) * NR + int'(clr_reg));
    clr_ok  = clr_en && (int'(clr_warp) < NW);
  end

  // Clear first, set last: a same-edge set on the same bit survives.
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
    end else begin
      if (clr_ok) pend_q[clr_idx] <= 1'b0;
      if (set_en) pend_q[set_idx] <= 1'b1;
    end
  end

  assign pend = pend_q;

  // R6: an issued destination is marked at the next cycle
  a_r6_mark_on_issue: assert property (@(posedge clk) disable iff (rst)
    set_en |=> pend_q[$past(set_idx)]);

  // R6: a writeback not overlapped by a set clears its mark
  a_r6_clear_on_wb: assert property (@(posedge clk) disable iff (rst)
    (clr_ok && !(set_en && set_idx == clr_idx)) |=> !pend_q[$past(clr_idx)]);

endmodule

// File: rtl/wis_pick.sv
module wis_pick
  import wis_pkg::*;
#(
  parameter int NW = 24,
  parameter int PW = 3,
  localparam int WIW = $clog2(NW)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NW-1:0]    elig,
  input  logic [NW*PW-1:0] prio,
  input  logic [WIW-1:0]   ptr,
  output logic             any,
  output logic [WIW-1:0]   sel
);
  logic [PW-1:0] best_p;
  int            best_d;

  always_comb begin
    any    = 1'b0;
    sel    = '0;
    best_p = '0;
    best_d = NW;
    for (int w = 0; w < NW; w++) begin
      if (elig[w]) begin
        if (!any || prio[w*PW +: PW] > best_p ||
            (prio[w*PW +: PW] == best_p && ring_dist(w, int'(ptr), NW) < best_d)) begin
          any    = 1'b1;
          sel    = WIW'(w);
          best_p = prio[w*PW +: PW];
          best_d = ring_dist(w, int'(ptr), NW);
        end
      end
    end
  end

  // R3: the chosen warp is one of the eligible ones
  a_r3_pick_is_eligible: assert property (@(posedge clk) disable iff (rst)
    any |-> elig[sel]);

  // R4: nothing eligible is left out when a choice is made
  a_r4_any_matches: assert property (@(posedge clk) disable iff (rst)
    any == (|elig));

endmodule

// File: rtl/wis_beat.sv
module wis_beat
  import wis_pkg::*;
#(
  parameter int NW = 24,
  parameter int WARP_THREADS = 32,
  parameter int LANES = 16,
  localparam int WIW = $clog2(NW),
  localparam int TBW = $clog2(WARP_THREADS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [WIW-1:0] start_warp,
  output logic           busy,
  output logic           beat_valid,
  output logic           beat_half,
  output logic [TBW-1:0] beat_base,
  output logic [WIW-1:0] beat_warp
);
  localparam int GROUPS = WARP_THREADS / LANES;
  localparam int BEATS  = GROUPS * CYCLES_PER_GROUP;
  localparam int CW     = $clog2(BEATS);
  localparam logic [CW-1:0] LAST = CW'(BEATS - 1);

  logic           act_q;
  logic [CW-1:0]  cnt_q;
  logic [WIW-1:0] warp_q;
  int             grp;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      warp_q <= '0;
    end else if (start) begin
      act_q  <= 1'b1;
      cnt_q  <= '0;
      warp_q <= start_warp;
    end else if (act_q) begin
      if (cnt_q == LAST) act_q <= 1'b0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    grp        = int'(cnt_q) / CYCLES_PER_GROUP;
    busy       = act_q && (cnt_q != LAST);
    beat_valid = act_q;
    beat_half  = (grp != 0);
    beat_base  = TBW'(grp * LANES);
    beat_warp  = warp_q;
  end

  // R7: beats advance one step per cycle and keep their warp
  a_r7_beat_step: assert property (@(posedge clk) disable iff (rst)
    (act_q && cnt_q != LAST) |=> (act_q && cnt_q == CW'($past(cnt_q) + 1'b1) &&
                                   warp_q == $past(warp_q)));

  // R8: a new warp never starts while beats remain
  a_r8_no_overlap: assert property (@(posedge clk) disable iff (rst)
    busy |-> !start);

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched #(
  parameter int NW = 24,
  parameter int LANES = 16,
  parameter int WARP_THREADS = 32,
  parameter int NR = 16,
  parameter int PW = 3,
  parameter int LW = 4,
  localparam int WIW = $clog2(NW),
  localparam int RW = $clog2(NR),
  localparam int TBW = $clog2(WARP_THREADS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NW-1:0]    warp_valid,
  input  logic [NW*PW-1:0] warp_prio,
  input  logic [NW*RW-1:0] warp_src_a,
  input  logic [NW*RW-1:0] warp_src_b,
  input  logic [NW*RW-1:0] warp_dst,
  input  logic [NW*LW-1:0] warp_lat,
  input  logic             wb_en,
  input  logic [WIW-1:0]   wb_warp,
  input  logic [RW-1:0]    wb_reg,
  output logic             issue_valid,
  output logic [WIW-1:0]   issue_warp,
  output logic [RW-1:0]    issue_dst,
  output logic [LW-1:0]    issue_lat,
  output logic             no_issue,
  output logic             beat_valid,
  output logic             beat_half,
  output logic [TBW-1:0]   beat_base,
  output logic [WIW-1:0]   beat_warp
);
  logic [NW*NR-1:0] pend;
  logic [NW-1:0]    elig;
  logic             any;
  logic [WIW-1:0]   sel;
  logic [WIW-1:0]   ptr_q;
  logic             phase_q;
  logic             busy;
  logic             slot_open;
  logic             fire;
  logic [RW-1:0]    sel_dst;
  logic [LW-1:0]    sel_lat;

  // Eligibility per warp from its scoreboard row
  for (genvar w = 0; w < NW; w++) begin : g_elig
    logic [NR-1:0] row;
    logic [RW-1:0] ra, rb, rd;
    assign row = pend[w*NR +: NR];
    assign ra  = warp_src_a[w*RW +: RW];
    assign rb  = warp_src_b[w*RW +: RW];
    assign rd  = warp_dst[w*RW +: RW];
    assign elig[w] = warp_valid[w] & ~row[ra] & ~row[rb] & ~row[rd];
  end

  wis_pick #(.NW(NW), .PW(PW)) u_pick (
    .clk  (clk),
    .rst  (rst),
    .elig (elig),
    .prio (warp_prio),
    .ptr  (ptr_q),
    .any  (any),
    .sel  (sel)
  );

  assign slot_open = !phase_q && !busy;
  assign fire      = slot_open && any;
  assign sel_dst   = warp_dst[sel*RW +: RW];
  assign sel_lat   = warp_lat[sel*LW +: LW];

  wis_scoreboard #(.NW(NW), .NR(NR)) u_sb (
    .clk      (clk),
    .rst      (rst),
    .set_en   (fire),
    .set_warp (sel),
    .set_reg  (sel_dst),
    .clr_en   (wb_en),
    .clr_warp (wb_warp),
    .clr_reg  (wb_reg),
    .pend     (pend)
  );

  wis_beat #(.NW(NW), .WARP_THREADS(WARP_THREADS), .LANES(LANES)) u_beat (
    .clk        (clk),
    .rst        (rst),
    .start      (fire),
    .start_warp (sel),
    .busy       (busy),
    .beat_valid (beat_valid),
    .beat_half  (beat_half),
    .beat_base  (beat_base),
    .beat_warp  (beat_warp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q     <= 1'b0;
      ptr_q       <= '0;
      issue_valid <= 1'b0;
      no_issue    <= 1'b0;
      issue_warp  <= '0;
      issue_dst   <= '0;
      issue_lat   <= '0;
    end else begin
      phase_q     <= ~phase_q;
      issue_valid <= 1'b0;
      no_issue    <= 1'b0;
      if (slot_open) begin
        if (any) begin
          issue_valid <= 1'b1;
          issue_warp  <= sel;
          issue_dst   <= sel_dst;
          issue_lat   <= sel_lat;
          ptr_q       <= (sel == WIW'(NW - 1)) ? '0 : sel + 1'b1;
        end else begin
          no_issue    <= 1'b1;
        end
      end
    end
  end

  // R2: slot outcomes never appear on consecutive cycles
  a_r2_half_rate: assert property (@(posedge clk) disable iff (rst)
    (issue_valid || no_issue) |=> !(issue_valid || no_issue));

  // R2: one outcome per slot at most
  a_r2_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(issue_valid && no_issue));

  // R8: at least four cycles between issues
  a_r8_spacing: assert property (@(posedge clk) disable iff (rst)
    issue_valid |=> !issue_valid ##1 !issue_valid ##1 !issue_valid);

  // R7: the first beat accompanies the issue and names the same warp
  a_r7_first_beat: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> (beat_valid && !beat_half && beat_base == '0 &&
                     beat_warp == issue_warp));

  // R9: an empty slot sends nothing into the datapath
  a_r9_quiet: assert property (@(posedge clk) disable iff (rst)
    no_issue |-> !beat_valid);

  // R9: the pointer stays put across an empty slot
  a_r9_ptr_hold: assert property (@(posedge clk) disable iff (rst)
    no_issue |-> $stable(ptr_q));

endmodule

// File: tb/warp_issue_sched_test.sv
`timescale 1ns/1ps
module warp_issue_sched_test;
  localparam int NW = 24, NR = 16, PW = 3, LW = 4, RW = 4, WIW = 5, TBW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic             b_v  [NW];
  logic [PW-1:0]    b_pr [NW];
  logic [RW-1:0]    b_sa [NW], b_sb [NW], b_d [NW];
  logic [LW-1:0]    b_l  [NW];
  logic [NW-1:0]    warp_valid;
  logic [NW*PW-1:0] warp_prio;
  logic [NW*RW-1:0] warp_src_a, warp_src_b, warp_dst;
  logic [NW*LW-1:0] warp_lat;
  logic             wb_en = 1'b0;
  logic [WIW-1:0]   wb_warp = '0;
  logic [RW-1:0]    wb_reg = '0;
  logic             issue_valid, no_issue, beat_valid, beat_half;
  logic [WIW-1:0]   issue_warp, beat_warp;
  logic [RW-1:0]    issue_dst;
  logic [LW-1:0]    issue_lat;
  logic [TBW-1:0]   beat_base;

  always_comb begin
    for (int w = 0; w < NW; w++) begin
      warp_valid[w]          = b_v[w];
      warp_prio[w*PW +: PW]  = b_pr[w];
      warp_src_a[w*RW +: RW] = b_sa[w];
      warp_src_b[w*RW +: RW] = b_sb[w];
      warp_dst[w*RW +: RW]   = b_d[w];
      warp_lat[w*LW +: LW]   = b_l[w];
    end
  end

  warp_issue_sched uut (
    .clk(clk), .rst(rst), .warp_valid(warp_valid), .warp_prio(warp_prio),
    .warp_src_a(warp_src_a), .warp_src_b(warp_src_b), .warp_dst(warp_dst),
    .warp_lat(warp_lat), .wb_en(wb_en), .wb_warp(wb_warp), .wb_reg(wb_reg),
    .issue_valid(issue_valid), .issue_warp(issue_warp), .issue_dst(issue_dst),
    .issue_lat(issue_lat), .no_issue(no_issue), .beat_valid(beat_valid),
    .beat_half(beat_half), .beat_base(beat_base), .beat_warp(beat_warp)
  );

  int checks = 0, failures = 0;
  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit m_sb [NW][NR];
  int m_ph, m_ptr, m_left, m_bw, cyc;
  int e_iv, e_ni, e_iw, e_dst, e_lat;
  int qw[$], qr[$], qd[$];

  function automatic bit m_ready(int w);
    return b_v[w] && !m_sb[w][b_sa[w]] && !m_sb[w][b_sb[w]] && !m_sb[w][b_d[w]];
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      foreach (m_sb[w, r]) m_sb[w][r] = 1'b0;
      m_ph = 0; m_ptr = 0; m_left = 0; m_bw = 0;
      e_iv = 0; e_ni = 0; e_iw = 0; e_dst = 0; e_lat = 0;
    end else begin
      int pick, bestp;
      bit open;
      open = (m_ph == 0) && (m_left <= 1);
      if (m_left > 0) m_left--;
      e_iv = 0; e_ni = 0; pick = -1; bestp = -1;
      if (open) begin
        for (int k = 0; k < NW; k++) begin
          int w;
          w = (m_ptr + k) % NW;
          if (m_ready(w) && int'(b_pr[w]) > bestp) begin
            pick = w; bestp = int'(b_pr[w]);
          end
        end
        if (pick < 0) e_ni = 1;
      end
      if (wb_en) m_sb[wb_warp][wb_reg] = 1'b0;
      if (pick >= 0) begin
        e_iv = 1; e_iw = pick; e_dst = b_d[pick]; e_lat = b_l[pick];
        m_sb[pick][b_d[pick]] = 1'b1;
        m_left = 4; m_bw = pick; m_ptr = (pick + 1) % NW;
        qw.push_back(pick); qr.push_back(int'(b_d[pick])); qd.push_back(cyc + int'(b_l[pick]));
      end
      m_ph = 1 - m_ph;
    end
  end

  // Sample away from the edge and compare every output with the model.
  task automatic step();
    @(negedge clk);
    chk("R2 issue_valid", issue_valid, e_iv);
    chk("R9 no_issue", no_issue, e_ni);
    if (e_iv) begin
      chk("R4 issue_warp", issue_warp, e_iw);
      chk("R10 issue_dst", issue_dst, e_dst);
      chk("R10 issue_lat", issue_lat, e_lat);
    end
    chk("R7 beat_valid", beat_valid, m_left > 0);
    if (m_left > 0) begin
      chk("R7 beat_half", beat_half, (4 - m_left) / 2);
      chk("R7 beat_base", beat_base, ((4 - m_left) / 2) * 16);
      chk("R7 beat_warp", beat_warp, m_bw);
    end
  endtask

  task automatic wait_issue(output int w);
    w = -1;
    for (int i = 0; i < 10; i++) begin
      step();
      if (issue_valid) begin w = issue_warp; return; end
    end
  endtask

  task automatic set_warp(int w, bit v, int p, int a, int b, int d, int l);
    b_v[w] = v; b_pr[w] = PW'(p); b_sa[w] = RW'(a); b_sb[w] = RW'(b);
    b_d[w] = RW'(d); b_l[w] = LW'(l);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int w, n, ni_cnt;
    for (int i = 0; i < NW; i++) set_warp(i, 0, 0, 0, 0, 0, 1);
    repeat (3) step();
    chk("R1 reset issue_valid", issue_valid, 0);
    chk("R1 reset no_issue", no_issue, 0);
    chk("R1 reset beat_valid", beat_valid, 0);
    rst = 1'b0;

    // R9: empty machine gives a no-issue in every other cycle, no beats
    ni_cnt = 0; n = 0;
    for (int i = 0; i < 4; i++) begin step(); ni_cnt += no_issue; n += beat_valid; end
    chk("R9 empty slots", ni_cnt, 2);
    chk("R9 no beats", n, 0);

    // R7/R10: one lone warp
    set_warp(5, 1, 0, 1, 2, 3, 7);
    wait_issue(w);
    b_v[5] = 0;
    chk("R10 lone warp", w, 5);
    chk("R10 lone dst", issue_dst, 3);
    chk("R10 lone lat", issue_lat, 7);
    chk("R7 beat0 half", beat_half, 0);
    step(); chk("R7 beat1 base", beat_base, 0);
    step(); chk("R7 beat2 half", beat_half, 1); chk("R7 beat2 base", beat_base, 16);
    step(); chk("R7 beat3 warp", beat_warp, 5);
    step(); chk("R7 beats done", beat_valid, 0);

    // R3/R6: reading a pending register blocks the warp until writeback
    set_warp(5, 1, 0, 3, 2, 4, 2);
    n = 0; ni_cnt = 0;
    for (int i = 0; i < 6; i++) begin step(); n += issue_valid; ni_cnt += no_issue; end
    chk("R3 hazard holds warp", n, 0);
    chk("R3 hazard gives no_issue", ni_cnt, 3);
    wb_en = 1; wb_warp = 5; wb_reg = 3;
    step();
    wb_en = 0;
    wait_issue(w);
    b_v[5] = 0;
    chk("R6 writeback frees warp", w, 5);

    // R4/R5: priority then rotation (pointer now 6)
    set_warp(2, 1, 1, 10, 11, 12, 3);
    set_warp(7, 1, 5, 10, 11, 12, 3);
    set_warp(9, 1, 5, 10, 11, 12, 3);
    wait_issue(w); b_v[7] = 0; set_warp(3, 1, 5, 10, 11, 12, 3);
    chk("R5 tie from pointer 6", w, 7);
    wait_issue(w); b_v[9] = 0;
    chk("R5 tie from pointer 8", w, 9);
    wait_issue(w); b_v[3] = 0;
    chk("R4 higher priority wins", w, 3);
    set_warp(23, 1, 1, 10, 11, 12, 3);
    wait_issue(w); b_v[23] = 0;
    chk("R5 tie before wrap", w, 23);
    wait_issue(w); b_v[2] = 0;
    chk("R5 pointer wrapped to 0", w, 2);

    // R8: two ready warps issue four cycles apart, busy slot silent
    set_warp(0, 1, 0, 10, 11, 13, 9);
    set_warp(1, 1, 0, 10, 11, 14, 9);
    wait_issue(w);
    chk("R8 first of pair", w, 0);
    n = 0; ni_cnt = 0;
    for (int i = 0; i < 8; i++) begin
      step(); n++; ni_cnt += no_issue;
      if (issue_valid) break;
    end
    chk("R8 issue spacing", n, 4);
    chk("R8 second of pair", issue_warp, 1);
    chk("R8 busy slot silent", ni_cnt, 0);
    b_v[0] = 0; b_v[1] = 0;

    // Random traffic with dense hazards, compared every clock
    for (int i = 0; i < NW; i++)
      set_warp(i, 1, $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7),
               $urandom_range(0, 7), $urandom_range(1, 15));
    for (int t = 0; t < 6000; t++) begin
      step();
      if (e_iv)
        set_warp(e_iw, 1, $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7),
                 $urandom_range(0, 7), $urandom_range(1, 15));
      for (int i = 0; i < NW; i++) if ($urandom_range(0, 31) == 0) b_v[i] = ~b_v[i];
      wb_en = 0;
      for (int k = 0; k < qd.size(); k++) begin
        if (qd[k] <= cyc) begin
          wb_en = 1; wb_warp = WIW'(qw[k]); wb_reg = RW'(qr[k]);
          qw.delete(k); qr.delete(k); qd.delete(k);
          break;
        end
      end
    end
    wb_en = 0;
    step();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule